// File: doc/BRIEF.md
# SDRAM Bank Command Legality Checker

This block is a passive monitor for an SDRAM command bus with four banks. On every clock it decodes the active-low strobes, the bank select bits, address bit A10 and the clock-enable samples into one command. It tracks the state of each bank and decides whether that command is allowed. Any violation is reported one cycle after the command as a flag with a reason code. An illegal command changes no bank state. A command aimed at one bank is judged only against that bank's state and timers. Refresh and mode-register commands are judged against all banks together.

Each bank has counters that enforce three timing rules: the delay from activate to column command, the minimum open time before precharge, and the spacing between activates. The cycle counts are set by parameters. A burst counter returns a bank to row active when its burst ends. If auto precharge was requested, the bank goes to idle instead, after a further precharge interval. The monitor also reports auto-precharge requests and entry into auto refresh, self refresh or power down.

Top module: `sdram_cmd_guard`

## Requirements
- R1: After reset every bank reads idle. Each bank's state uses 2 bits of `bank_state_o`, bank n at bits [2n+1:2n], coded 0 idle, 1 row active, 2 read burst, 3 write burst. `illegal_o`, `reason_o`, `auto_pre_o` and `entry_o` are all 0.
- R2: An activate to an idle bank opens it (state 1). An activate to a bank in state 1, 2 or 3 is illegal with reason 3.
- R3: A read or write to an idle bank is illegal with reason 2.
- R4: A legal read or write puts the bank in state 2 or 3 for BURST_LEN cycles, after which it returns to state 1. `auto_pre_o` is 1 in the following cycle exactly when A10 was high on that command.
- R5: A burst started with A10 high keeps the bank in its burst state for BURST_LEN + T_RP cycles, and then the bank goes idle. During that time a read, write, precharge or burst stop to that bank is illegal with reason 7.
- R6: During a burst without auto precharge, a read or write to the same bank restarts the burst in the new direction. A burst stop returns the bank to state 1. A precharge makes it idle.
- R7: A precharge to an idle bank is legal and has no effect. A precharge issued fewer than T_RAS cycles after the bank's activate is illegal with reason 5.
- R8: A read or write issued fewer than T_RCD cycles after the bank's activate is illegal with reason 4.
- R9: An activate issued fewer than T_RRD cycles after the last accepted activate is illegal with reason 6.
- R10: A refresh or mode-register command while any bank is not idle is illegal with reason 1. When all banks are idle, a refresh gives `entry_o` = 1 (auto refresh) with `cke` high and 2 (self refresh) with `cke` low.
- R11: A deselect with `cke` low while all banks are idle gives `entry_o` = 3 (power down).
- R12: With `cke_prev` low the strobes are not decoded. No flag, no auto-precharge pulse, no entry code and no bank change result.
- R13: Verdicts appear in the cycle after the command. An illegal command sets `illegal_o` with a nonzero `reason_o` and leaves all bank states as they would be without it. Strobe codes {cs_n,ras_n,cas_n,we_n} are: 1xxx deselect, 0111 NOP, 0011 activate, 0101 read, 0100 write, 0110 burst stop, 0010 precharge, 0001 refresh, 0000 mode register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| ba | input | BANK_BITS | Bank select |
| a10 | input | 1 | Address bit 10 (auto-precharge select on read/write) |
| cke | input | 1 | Clock enable in the current cycle |
| cke_prev | input | 1 | Clock enable in the previous cycle |
| bank_state_o | output | 2*2^BANK_BITS | Packed per-bank state |
| illegal_o | output | 1 | Illegal-command flag |
| reason_o | output | 3 | Reason code, 0 when legal |
| auto_pre_o | output | 1 | Accepted read/write requested auto precharge |
| entry_o | output | 2 | 0 none, 1 auto refresh, 2 self refresh, 3 power down |

## Verification
A bank stuck in the wrong state shows up on `bank_state_o` at the next check. It also flips the verdict on the next command aimed at that bank: an activate that should be rejected is accepted, or a column command that should pass is rejected. That verdict is visible one cycle later. A timer that is off by one changes the flag only at its exact boundary cycle, so the commands are placed exactly one cycle before and at the end of each interval. An auto-precharge flag that fails to clear leaves a bank stuck in its burst state past BURST_LEN + T_RP cycles, and the state check after that window catches it.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_ACTIVE = 2'd1,
        BK_READ   = 2'd2,
        BK_WRITE  = 2'd3
    } bank_st_e;

    typedef enum logic [3:0] {
        C_NONE, C_DESEL, C_NOP, C_ACT, C_RD, C_WR, C_BST, C_PRE, C_REF, C_MRS
    } cmd_e;

    typedef enum logic [2:0] {
        WHY_NONE     = 3'd0,
        WHY_BUSY_ALL = 3'd1,
        WHY_CLOSED   = 3'd2,
        WHY_OPEN     = 3'd3,
        WHY_RCD      = 3'd4,
        WHY_RAS      = 3'd5,
        WHY_RRD      = 3'd6,
        WHY_APLOCK   = 3'd7
    } why_e;

    typedef enum logic [1:0] {
        ENT_NONE     = 2'd0,
        ENT_AUTO_REF = 2'd1,
        ENT_SELF_REF = 2'd2,
        ENT_PDOWN    = 2'd3
    } entry_e;
endpackage

// File: rtl/sdg_decode.sv
module sdg_decode
    import sdg_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke_prev,
    output cmd_e cmd_o
);
    always_comb begin
        if (!cke_prev) begin
            cmd_o = C_NONE;
        end else if (cs_n) begin
            cmd_o = C_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd_o = C_NOP;
                3'b011:  cmd_o = C_ACT;
                3'b101:  cmd_o = C_RD;
                3'b100:  cmd_o = C_WR;
                3'b110:  cmd_o = C_BST;
                3'b010:  cmd_o = C_PRE;
                3'b001:  cmd_o = C_REF;
                default: cmd_o = C_MRS;
            endcase
        end
    end
endmodule

// File: rtl/sdg_bank.sv
module sdg_bank
    import sdg_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 5,
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 2,
    parameter int CW        = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     go_act,
    input  logic     go_rd,
    input  logic     go_wr,
    input  logic     go_pre,
    input  logic     go_bst,
    input  logic     ap_sel,
    output bank_st_e st_o,
    output logic     rcd_ok_o,
    output logic     ras_ok_o,
    output logic     ap_lock_o
);
    typedef struct packed {
        bank_st_e        st;
        logic            ap;
        logic            closing;
        logic [CW-1:0]   cnt;
        logic [CW-1:0]   rcd;
        logic [CW-1:0]   ras;
    } bk_t;

    bk_t q, d;

    always_comb begin
        d = q;
        if (q.rcd != '0) d.rcd = q.rcd - 1'b1;
        if (q.ras != '0) d.ras = q.ras - 1'b1;

        // burst and trailing auto-precharge progress
        if (q.st == BK_READ || q.st == BK_WRITE) begin
            if (q.cnt != '0) begin
                d.cnt = q.cnt - 1'b1;
            end else if (q.closing) begin
                d.st      = BK_IDLE;
                d.ap      = 1'b0;
                d.closing = 1'b0;
            end else if (q.ap) begin
                d.closing = 1'b1;
                d.cnt     = CW'(T_RP - 1);
            end else begin
                d.st = BK_ACTIVE;
            end
        end

        // accepted commands override progress
        if (go_act) begin
            d.st  = BK_ACTIVE;
            d.rcd = CW'(T_RCD - 1);
            d.ras = CW'(T_RAS - 1);
        end
        if (go_rd || go_wr) begin
            d.st      = go_rd ? BK_READ : BK_WRITE;
            d.ap      = ap_sel;
            d.closing = 1'b0;
            d.cnt     = CW'(BURST_LEN - 1);
        end
        if (go_pre) begin
            d.st      = BK_IDLE;
            d.ap      = 1'b0;
            d.closing = 1'b0;
        end
        if (go_bst) begin
            d.st = BK_ACTIVE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign st_o      = q.st;
    assign rcd_ok_o  = (q.rcd == '0);
    assign ras_ok_o  = (q.ras == '0);
    assign ap_lock_o = q.ap;
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
    import sdg_pkg::*;
#(
    parameter int BANK_BITS = 2,
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 5,
    parameter int T_RRD     = 2,
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cs_n,
    input  logic                            ras_n,
    input  logic                            cas_n,
    input  logic                            we_n,
    input  logic [BANK_BITS-1:0]            ba,
    input  logic                            a10,
    input  logic                            cke,
    input  logic                            cke_prev,
    output logic [2*(1<<BANK_BITS)-1:0]     bank_state_o,
    output logic                            illegal_o,
    output logic [2:0]                      reason_o,
    output logic                            auto_pre_o,
    output logic [1:0]                      entry_o
);
    localparam int NB    = 1 << BANK_BITS;
    localparam int TM_A  = (T_RCD > T_RAS) ? T_RCD : T_RAS;
    localparam int TM_B  = (T_RRD > BURST_LEN) ? T_RRD : BURST_LEN;
    localparam int TM_C  = (TM_A > TM_B) ? TM_A : TM_B;
    localparam int T_MAX = (TM_C > T_RP) ? TM_C : T_RP;
    localparam int CW    = $clog2(T_MAX + 1);

    typedef struct packed {
        logic [CW-1:0] rrd;
        logic          bad;
        why_e          why;
        logic          ap;
        entry_e        ent;
    } top_t;

    top_t q, d;
    cmd_e cmd;

    bank_st_e       st_w [NB];
    logic [NB-1:0]  rcd_ok_w, ras_ok_w, ap_lock_w;
    logic           go_act, go_rd, go_wr, go_pre, go_bst;
    logic           all_idle;
    bank_st_e       sel_st;

    sdg_decode u_decode (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .cke_prev (cke_prev),
        .cmd_o    (cmd)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bank
        localparam logic [BANK_BITS-1:0] ID = BANK_BITS'(i);
        sdg_bank #(
            .T_RCD(T_RCD), .T_RAS(T_RAS), .BURST_LEN(BURST_LEN), .T_RP(T_RP), .CW(CW)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .go_act    (go_act && (ba == ID)),
            .go_rd     (go_rd  && (ba == ID)),
            .go_wr     (go_wr  && (ba == ID)),
            .go_pre    (go_pre && (ba == ID)),
            .go_bst    (go_bst && (ba == ID)),
            .ap_sel    (a10),
            .st_o      (st_w[i]),
            .rcd_ok_o  (rcd_ok_w[i]),
            .ras_ok_o  (ras_ok_w[i]),
            .ap_lock_o (ap_lock_w[i])
        );
        assign bank_state_o[2*i +: 2] = st_w[i];
    end

    always_comb begin
        all_idle = 1'b1;
        for (int i = 0; i < NB; i++) begin
            if (st_w[i] != BK_IDLE) all_idle = 1'b0;
        end
        sel_st = st_w[ba];
    end

    always_comb begin
        d = q;
        if (q.rrd != '0) d.rrd = q.rrd - 1'b1;
        d.why  = WHY_NONE;
        d.ap   = 1'b0;
        d.ent  = ENT_NONE;
        go_act = 1'b0;
        go_rd  = 1'b0;
        go_wr  = 1'b0;
        go_pre = 1'b0;
        go_bst = 1'b0;
        case (cmd)
            C_MRS: begin
                if (!all_idle) d.why = WHY_BUSY_ALL;
            end
            C_REF: begin
                if (!all_idle) d.why = WHY_BUSY_ALL;
                else           d.ent = cke ? ENT_AUTO_REF : ENT_SELF_REF;
            end
            C_ACT: begin
                if (sel_st != BK_IDLE)  d.why = WHY_OPEN;
                else if (q.rrd != '0)   d.why = WHY_RRD;
                else begin
                    go_act = 1'b1;
                    d.rrd  = CW'(T_RRD - 1);
                end
            end
            C_RD, C_WR: begin
                if (sel_st == BK_IDLE)      d.why = WHY_CLOSED;
                else if (ap_lock_w[ba])     d.why = WHY_APLOCK;
                else if (!rcd_ok_w[ba])     d.why = WHY_RCD;
                else begin
                    go_rd = (cmd == C_RD);
                    go_wr = (cmd == C_WR);
                    d.ap  = a10;
                end
            end
            C_PRE: begin
                if (sel_st == BK_IDLE)      ; // nothing to close
                else if (ap_lock_w[ba])     d.why = WHY_APLOCK;
                else if (!ras_ok_w[ba])     d.why = WHY_RAS;
                else                        go_pre = 1'b1;
            end
            C_BST: begin
                if (ap_lock_w[ba])          d.why = WHY_APLOCK;
                else if (sel_st == BK_READ || sel_st == BK_WRITE) go_bst = 1'b1;
            end
            C_DESEL: begin
                if (!cke && all_idle) d.ent = ENT_PDOWN;
            end
            default: ;
        endcase
        d.bad = (d.why != WHY_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign illegal_o  = q.bad;
    assign reason_o   = q.why;
    assign auto_pre_o = q.ap;
    assign entry_o    = q.ent;
endmodule

// File: rtl/sdg_guard_chk.sv
module sdg_guard_chk #(
    parameter int BANK_BITS = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cs_n,
    input logic                        ras_n,
    input logic                        cas_n,
    input logic                        we_n,
    input logic [BANK_BITS-1:0]        ba,
    input logic                        a10,
    input logic                        cke,
    input logic                        cke_prev,
    input logic [2*(1<<BANK_BITS)-1:0] bank_state_o,
    input logic                        illegal_o,
    input logic [2:0]                  reason_o,
    input logic                        auto_pre_o,
    input logic [1:0]                  entry_o
);
    logic       live, c_act, c_rw, c_mode, c_dsl, idle_all;
    logic [1:0] tgt;

    assign live     = cke_prev && !cs_n;
    assign c_act    = live && ({ras_n, cas_n, we_n} == 3'b011);
    assign c_rw     = live && ({ras_n, cas_n} == 2'b10);
    assign c_mode   = live && ({ras_n, cas_n} == 2'b00);
    assign c_dsl    = cke_prev && cs_n;
    assign tgt      = bank_state_o[{ba, 1'b0} +: 2];
    assign idle_all = (bank_state_o == '0);

    assert_act_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_act && tgt != 2'd0) |=> (illegal_o && reason_o == 3'd3));

    assert_rw_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rw && tgt == 2'd0) |=> (illegal_o && reason_o == 3'd2));

    assert_ap_needs_a10_R4: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre_o |-> (!illegal_o && $past(a10) && $past(c_rw)));

    assert_mode_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (c_mode && !idle_all) |=> (illegal_o && reason_o == 3'd1));

    assert_pdown_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (c_dsl && !cke && idle_all) |=> (entry_o == 2'd3));

    assert_cke_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_prev |=> (!illegal_o && !auto_pre_o && entry_o == 2'd0));
endmodule

bind sdram_cmd_guard sdg_guard_chk #(.BANK_BITS(BANK_BITS)) u_guard_chk (.*);

// File: tb/test_sdram_cmd_guard.sv
module test_sdram_cmd_guard;
    localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD  = 4'b0101,
                           K_WR  = 4'b0100, K_BST = 4'b0110, K_PRE = 4'b0010,
                           K_REF = 4'b0001, K_MRS = 4'b0000, K_DSL = 4'b1111;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, cs_n, ras_n, cas_n, we_n, a10, cke, cke_prev;
    logic [1:0] ba;
    logic [7:0] bank_state_o;
    logic       illegal_o, auto_pre_o;
    logic [2:0] reason_o;
    logic [1:0] entry_o;

    sdram_cmd_guard #(
        .BANK_BITS(2), .T_RCD(3), .T_RAS(5), .T_RRD(2), .BURST_LEN(4), .T_RP(2)
    ) i_sdram_cmd_guard (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .cke(cke), .cke_prev(cke_prev),
        .bank_state_o(bank_state_o), .illegal_o(illegal_o), .reason_o(reason_o),
        .auto_pre_o(auto_pre_o), .entry_o(entry_o)
    );

    typedef struct {
        logic       bad;
        logic [2:0] why;
        logic       ap;
        logic [1:0] ent;
        string      req;
    } exp_t;

    exp_t q[$];
    exp_t mon_e;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;

    // monitor: compares the verdict produced one edge after each command
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            mon_e = q.pop_front();
            total++;
            if ({illegal_o, reason_o, auto_pre_o, entry_o} !==
                {mon_e.bad, mon_e.why, mon_e.ap, mon_e.ent}) begin
                bad++;
                $display("FAIL %s: got illegal=%0b reason=%0d ap=%0b entry=%0d, want illegal=%0b reason=%0d ap=%0b entry=%0d",
                         mon_e.req, illegal_o, reason_o, auto_pre_o, entry_o,
                         mon_e.bad, mon_e.why, mon_e.ap, mon_e.ent);
            end
        end
    end

    task automatic cyc(input logic [3:0] k, input logic [1:0] b, input logic a,
                       input logic ck, input logic ckp, input logic eb,
                       input logic [2:0] ew, input logic eap, input logic [1:0] ee,
                       input string req);
        exp_t e;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = k;
        ba = b; a10 = a; cke = ck; cke_prev = ckp;
        e.bad = eb; e.why = ew; e.ap = eap; e.ent = ee; e.req = req;
        q.push_back(e);
        @(posedge clk);
        #1;
    endtask

    task automatic ok(input logic [3:0] k, input logic [1:0] b, input string req);
        cyc(k, b, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 2'd0, req);
    endtask

    task automatic bad_cmd(input logic [3:0] k, input logic [1:0] b,
                           input logic [2:0] why, input string req);
        cyc(k, b, 1'b0, 1'b1, 1'b1, 1'b1, why, 1'b0, 2'd0, req);
    endtask

    task automatic st(input int b, input logic [1:0] e, input string req);
        total++;
        if (bank_state_o[2*b +: 2] !== e) begin
            bad++;
            $display("FAIL %s: bank%0d state got %0d want %0d", req, b,
                     bank_state_o[2*b +: 2], e);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, got hang want completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = K_DSL;
        ba = 2'd0; a10 = 1'b0; cke = 1'b1; cke_prev = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        total++;
        if (bank_state_o !== 8'h00 || illegal_o !== 1'b0 || reason_o !== 3'd0 ||
            auto_pre_o !== 1'b0 || entry_o !== 2'd0) begin
            bad++;
            $display("FAIL R1: got state=%h ill=%0b why=%0d ap=%0b ent=%0d want all 0",
                     bank_state_o, illegal_o, reason_o, auto_pre_o, entry_o);
        end

        bad_cmd(K_RD, 2'd0, 3'd2, "R3 read to idle bank");
        st(0, 2'd0, "R13 state untouched");
        ok(K_ACT, 2'd0, "R2 activate idle bank");
        st(0, 2'd1, "R2");
        bad_cmd(K_ACT, 2'd1, 3'd6, "R9 activate too soon");
        st(1, 2'd0, "R13 state untouched");
        ok(K_ACT, 2'd1, "R9 activate at spacing");
        st(1, 2'd1, "R9");
        bad_cmd(K_RD, 2'd1, 3'd4, "R8 read before row-column delay");
        st(1, 2'd1, "R8");
        bad_cmd(K_PRE, 2'd1, 3'd5, "R7 precharge before active time");
        st(1, 2'd1, "R7");
        ok(K_RD, 2'd0, "R4 read without auto precharge");
        st(0, 2'd2, "R4 burst state");
        bad_cmd(K_ACT, 2'd0, 3'd3, "R2 activate open bank");
        st(0, 2'd2, "R13 state untouched");
        ok(K_NOP, 2'd0, "R4 nop");
        ok(K_NOP, 2'd0, "R4 nop");
        st(0, 2'd2, "R4 burst last cycle");
        ok(K_NOP, 2'd0, "R4 nop");
        st(0, 2'd1, "R4 burst ended");

        cyc(K_WR, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 1'b1, 2'd0, "R4 write with auto precharge");
        st(0, 2'd3, "R5");
        bad_cmd(K_RD, 2'd0, 3'd7, "R5 read during auto precharge");
        for (int i = 0; i < 4; i++) ok(K_NOP, 2'd0, "R5 nop");
        st(0, 2'd3, "R5 still closing");
        ok(K_NOP, 2'd0, "R5 nop");
        st(0, 2'd0, "R5 idle after precharge");

        ok(K_RD, 2'd1, "R6 read bank1");
        st(1, 2'd2, "R6");
        bad_cmd(K_REF, 2'd0, 3'd1, "R10 refresh with open bank");
        ok(K_WR, 2'd1, "R6 write interrupts read");
        st(1, 2'd3, "R6 write burst");
        ok(K_BST, 2'd1, "R6 burst stop");
        st(1, 2'd1, "R6 back to active");
        ok(K_RD, 2'd1, "R6 read again");
        ok(K_PRE, 2'd1, "R6 precharge interrupts read");
        st(1, 2'd0, "R6 idle");
        ok(K_PRE, 2'd2, "R7 precharge idle bank");
        st(2, 2'd0, "R7 no effect");

        cyc(K_REF, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 2'd1, "R10 auto refresh");
        cyc(K_REF, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 2'd2, "R10 self refresh");
        ok(K_MRS, 2'd0, "R10 mode register all idle");
        cyc(K_DSL, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 2'd3, "R11 power down");
        cyc(K_RD, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 2'd0, "R12 gated read");
        cyc(K_ACT, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 2'd0, "R12 gated activate");
        st(2, 2'd0, "R12 no state change");
        ok(K_ACT, 2'd2, "R2 activate bank2");
        st(2, 2'd1, "R2");
        bad_cmd(K_MRS, 2'd0, 3'd1, "R10 mode register with open bank");
        ok(K_NOP, 2'd0, "R13 flag cleared");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule